// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Line-Invalidate Hint

This block is a direct-mapped, write-back level-one data cache. It sits between a single-request load/store port and a next-level memory port. The set index comes from the address by plain modulo, with no hashing. Two addresses that differ by a whole multiple of the cache capacity therefore compete for one set. Misses write back a dirty victim and then refill the whole line. The next-level port moves one line per transaction. It also has two single-word commands, which the uncached path uses.

An invalidate command is a hint and never causes memory traffic by itself. If it hits a clean resident line, that line is dropped on the spot. If it hits a dirty line, the line only gets a flush mark. The next load or store that hits the marked line completes normally, then writes the line back and drops it. An access carrying the no-cache attribute goes straight to memory as a single-word read or write and leaves the cache untouched. The attribute only takes effect while the privilege input is high; without it the access is an ordinary cached one.

The controller is a single state machine:
- IDLE accepts a request. It goes to BYP_REQ for a privileged no-cache load or store, and to LOOKUP for everything else.
- LOOKUP compares the tag.
  - An invalidate goes to RESP.
  - A hit goes to RESP, or to DROP_WB if the line is flush-marked.
  - A miss goes to EVICT when the victim is dirty, and to FILL_REQ otherwise.
- EVICT goes to FILL_REQ once its line write is accepted.
- FILL_REQ goes to FILL_WAIT once its line read is accepted.
- FILL_WAIT returns to LOOKUP when the line arrives.
- DROP_WB goes to RESP once its line write is accepted.
- BYP_REQ goes to RESP after a write, or to BYP_WAIT after a read.
- BYP_WAIT goes to RESP on the returned word.
- RESP pulses the response and returns to IDLE.

Top module: `inval_hint_dcache`

## Requirements
- R1: After reset every line is invalid, req_ready is high, and resp_valid and mem_req_valid are low.
- R2: With default parameters the address fields are: byte offset [1:0], word-in-line [3:2], set index [7:4], tag [11:8]. A load miss issues one line read at the line-aligned address and returns the addressed word. A later access to the same line hits with no next-level traffic.
- R3: Two addresses 256 bytes apart (the default capacity) map to the same set. Accessing the second evicts the first. A dirty victim is written back with a line write at its own line address before the refill read.
- R4: A store hit updates the addressed word and marks the line dirty, without traffic. A clean victim is replaced with no line write.
- R5: An invalidate that hits a dirty line causes no traffic and only marks the line. The next hitting load returns correct data, then one line write stores the line and the line is dropped, so the access after that misses.
- R6: An invalidate that hits a clean line drops it at once, without traffic. The next load misses and returns the current next-level contents.
- R7: An invalidate that misses changes nothing. Every invalidate raises resp_valid exactly one clock edge after the edge that accepted it.
- R8: A load or store with req_nocache high while priv_mode is high bypasses the cache. It is a word read (cmd 2'b10) or word write (cmd 2'b11) with the word in mem_req_wline / mem_rline bits [31:0], and resident lines are left as they were. An invalidate is never bypassed.
- R9: With priv_mode low, req_nocache is ignored and the access is cached normally.
- R10: A store that hits a flush-marked line merges its word, then writes the merged line back and drops it.
- R11: Next-level commands are 2'b00 line read and 2'b01 line write. A line holds word w at bits [32w+31:32w]. Line commands carry line-aligned addresses. A request stays stable until mem_req_ready, and a read completes on mem_rvalid.
- R12: req_op encodes 2'b00 load, 2'b01 store, 2'b10 invalidate; 2'b11 acts as a load. req_ready is low from acceptance until completion. Each accepted request produces exactly one single-cycle resp_valid, with resp_rdata valid for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_op | input | 2 | Operation: load, store, invalidate |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_nocache | input | 1 | Bypass attribute |
| priv_mode | input | 1 | Privilege qualifying the bypass attribute |
| resp_valid | output | 1 | Completion pulse |
| resp_rdata | output | DATA_W | Load result |
| mem_req_valid | output | 1 | Next-level request present |
| mem_req_ready | input | 1 | Next-level request accepted |
| mem_req_cmd | output | 2 | Line read, line write, word read, word write |
| mem_req_addr | output | ADDR_W | Next-level byte address |
| mem_req_wline | output | LINE_W | Write line (word writes use bits [31:0]) |
| mem_rvalid | input | 1 | Read data returned |
| mem_rline | input | LINE_W | Returned line or word |

## Verification
The bench drives a dirty-line invalidate followed by a load. A design that wrote back at the invalidate, or never wrote back, shows up in the traffic counts. A design that forgot to drop the line shows up as a missing refill on the following access. An invalidate of a clean line is followed by a change to next-level memory behind the cache, so a line that was not really discarded returns stale data. Aliased addresses one capacity apart check modulo indexing and the write-back order. A privileged no-cache read of a dirty-cached word must return the memory copy, and the cached copy must then still hit; a bypass that allocated, or an attribute honoured without privilege, breaks one of those.

// File: rtl/ihc_pkg.sv
package ihc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_INVAL = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        MC_LINE_RD = 2'b00,
        MC_LINE_WR = 2'b01,
        MC_WORD_RD = 2'b10,
        MC_WORD_WR = 2'b11
    } mcmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOOKUP,
        S_EVICT,
        S_FILL_REQ,
        S_FILL_WAIT,
        S_DROP_WB,
        S_BYP_REQ,
        S_BYP_WAIT,
        S_RESP
    } state_e;

endpackage

// File: rtl/ihc_addr_split.sv
module ihc_addr_split #(
    parameter int ADDR_W    = 12,
    parameter int BYTE_OFF  = 2,
    parameter int WORD_BITS = 2,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [TAG_W-1:0]     tag,
    output logic [IDX_W-1:0]     idx,
    output logic [WORD_BITS-1:0] word,
    output logic [ADDR_W-1:0]    line_base,
    output logic [ADDR_W-1:0]    word_addr
);
    localparam int OFF_W = BYTE_OFF + WORD_BITS;

    // Plain modulo indexing: the set is a direct slice of the address.
    assign tag       = addr[ADDR_W-1 -: TAG_W];
    assign idx       = addr[OFF_W +: IDX_W];
    assign word      = addr[BYTE_OFF +: WORD_BITS];
    assign line_base = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign word_addr = {addr[ADDR_W-1:BYTE_OFF], {BYTE_OFF{1'b0}}};

endmodule

// File: rtl/ihc_line_store.sv
module ihc_line_store #(
    parameter int SETS   = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic              rd_mark,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              wr_mark,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    logic [SETS-1:0]   valid_vec;
    logic [SETS-1:0]   dirty_vec;
    logic [SETS-1:0]   mark_vec;
    logic [TAG_W-1:0]  tag_arr  [SETS];
    logic [LINE_W-1:0] line_arr [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic              hit_wr;
        logic              v_r, d_r, m_r;
        logic [TAG_W-1:0]  tag_r;
        logic [LINE_W-1:0] line_r;

        assign hit_wr = wr_en && (wr_idx == IDX_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_r <= 1'b0;
                d_r <= 1'b0;
                m_r <= 1'b0;
            end else if (hit_wr) begin
                v_r <= wr_valid;
                d_r <= wr_dirty;
                m_r <= wr_mark;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_wr) begin
                tag_r  <= wr_tag;
                line_r <= wr_line;
            end
        end

        assign valid_vec[s] = v_r;
        assign dirty_vec[s] = d_r;
        assign mark_vec[s]  = m_r;
        assign tag_arr[s]   = tag_r;
        assign line_arr[s]  = line_r;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_dirty = dirty_vec[rd_idx];
    assign rd_mark  = mark_vec[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];
    assign rd_line  = line_arr[rd_idx];

endmodule

// File: rtl/ihc_fsm.sv
module ihc_fsm
    import ihc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int WORD_BITS  = 2,
    parameter int IDX_W      = 4,
    parameter int TAG_W      = 4,
    parameter int OFF_W      = 4,
    parameter int LINE_W     = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    // request side
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 req_nocache,
    input  logic                 priv_mode,
    output logic                 resp_valid,
    output logic [DATA_W-1:0]    resp_rdata,
    // next-level side
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [1:0]           mem_req_cmd,
    output logic [ADDR_W-1:0]    mem_req_addr,
    output logic [LINE_W-1:0]    mem_req_wline,
    input  logic                 mem_rvalid,
    input  logic [LINE_W-1:0]    mem_rline,
    // address fields of the held request
    output logic [ADDR_W-1:0]    cur_addr,
    input  logic [TAG_W-1:0]     cur_tag,
    input  logic [IDX_W-1:0]     cur_idx,
    input  logic [WORD_BITS-1:0] cur_word,
    input  logic [ADDR_W-1:0]    cur_line_base,
    input  logic [ADDR_W-1:0]    cur_word_addr,
    // line store
    input  logic                 rd_valid,
    input  logic                 rd_dirty,
    input  logic                 rd_mark,
    input  logic [TAG_W-1:0]     rd_tag,
    input  logic [LINE_W-1:0]    rd_line,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic                 wr_valid,
    output logic                 wr_dirty,
    output logic                 wr_mark,
    output logic [TAG_W-1:0]     wr_tag,
    output logic [LINE_W-1:0]    wr_line
);
    state_e              state_q, state_d;
    logic [1:0]          op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;

    logic                hit;
    logic                is_store;
    logic                is_inval;
    logic                take_bypass;
    logic [DATA_W-1:0]   hit_word;
    logic [LINE_W-1:0]   merged_line;
    logic [ADDR_W-1:0]   victim_addr;

    assign cur_addr    = addr_q;
    assign hit         = rd_valid && (rd_tag == cur_tag);
    assign is_store    = (op_q == OP_STORE);
    assign is_inval    = (op_q == OP_INVAL);
    assign take_bypass = req_nocache && priv_mode && (req_op != OP_INVAL);
    assign victim_addr = {rd_tag, cur_idx, {OFF_W{1'b0}}};

    // Word select and store merge on the indexed line.
    always_comb begin
        hit_word    = '0;
        merged_line = rd_line;
        for (int w = 0; w < LINE_WORDS; w++) begin
            if (cur_word == WORD_BITS'(w)) begin
                hit_word                         = rd_line[w*DATA_W +: DATA_W];
                merged_line[w*DATA_W +: DATA_W] = wdata_q;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Held request and load result.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                op_q    <= req_op;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == S_LOOKUP && hit && !is_inval && !is_store)
                rdata_q <= hit_word;
            if (state_q == S_BYP_WAIT && mem_rvalid)
                rdata_q <= mem_rline[DATA_W-1:0];
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (req_valid) state_d = take_bypass ? S_BYP_REQ : S_LOOKUP;
            S_LOOKUP: begin
                if (is_inval)                 state_d = S_RESP;
                else if (hit)                 state_d = rd_mark ? S_DROP_WB : S_RESP;
                else if (rd_valid && rd_dirty) state_d = S_EVICT;
                else                          state_d = S_FILL_REQ;
            end
            S_EVICT:     if (mem_req_ready) state_d = S_FILL_REQ;
            S_FILL_REQ:  if (mem_req_ready) state_d = S_FILL_WAIT;
            S_FILL_WAIT: if (mem_rvalid)    state_d = S_LOOKUP;
            S_DROP_WB:   if (mem_req_ready) state_d = S_RESP;
            S_BYP_REQ:   if (mem_req_ready) state_d = is_store ? S_RESP : S_BYP_WAIT;
            S_BYP_WAIT:  if (mem_rvalid)    state_d = S_RESP;
            S_RESP:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        resp_valid    = (state_q == S_RESP);
        resp_rdata    = rdata_q;
        mem_req_valid = 1'b0;
        mem_req_cmd   = MC_LINE_RD;
        mem_req_addr  = cur_line_base;
        mem_req_wline = rd_line;
        wr_en         = 1'b0;
        wr_idx        = cur_idx;
        wr_valid      = rd_valid;
        wr_dirty      = rd_dirty;
        wr_mark       = rd_mark;
        wr_tag        = rd_tag;
        wr_line       = rd_line;
        unique case (state_q)
            S_LOOKUP: begin
                if (is_inval && hit) begin
                    // clean: drop now; dirty: flag for drop on next touch
                    wr_en    = 1'b1;
                    wr_valid = rd_dirty;
                    wr_mark  = rd_dirty;
                end else if (!is_inval && hit && is_store) begin
                    wr_en    = 1'b1;
                    wr_dirty = 1'b1;
                    wr_line  = merged_line;
                end
            end
            S_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_cmd   = MC_LINE_WR;
                mem_req_addr  = victim_addr;
            end
            S_FILL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_cmd   = MC_LINE_RD;
            end
            S_FILL_WAIT: begin
                if (mem_rvalid) begin
                    wr_en    = 1'b1;
                    wr_valid = 1'b1;
                    wr_dirty = 1'b0;
                    wr_mark  = 1'b0;
                    wr_tag   = cur_tag;
                    wr_line  = mem_rline;
                end
            end
            S_DROP_WB: begin
                mem_req_valid = 1'b1;
                mem_req_cmd   = MC_LINE_WR;
                mem_req_addr  = victim_addr;
                if (mem_req_ready) begin
                    wr_en    = 1'b1;
                    wr_valid = 1'b0;
                    wr_dirty = 1'b0;
                    wr_mark  = 1'b0;
                end
            end
            S_BYP_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_cmd   = is_store ? MC_WORD_WR : MC_WORD_RD;
                mem_req_addr  = cur_word_addr;
                mem_req_wline = LINE_W'(wdata_q);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/inval_hint_dcache.sv
module inval_hint_dcache #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic                         req_nocache,
    input  logic                         priv_mode,
    output logic                         resp_valid,
    output logic [DATA_W-1:0]            resp_rdata,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [1:0]                   mem_req_cmd,
    output logic [ADDR_W-1:0]            mem_req_addr,
    output logic [DATA_W*LINE_WORDS-1:0] mem_req_wline,
    input  logic                         mem_rvalid,
    input  logic [DATA_W*LINE_WORDS-1:0] mem_rline
);
    localparam int BYTE_OFF  = $clog2(DATA_W / 8);
    localparam int WORD_BITS = $clog2(LINE_WORDS);
    localparam int IDX_W     = $clog2(SETS);
    localparam int OFF_W     = BYTE_OFF + WORD_BITS;
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W    = DATA_W * LINE_WORDS;

    logic [ADDR_W-1:0]    cur_addr;
    logic [TAG_W-1:0]     cur_tag;
    logic [IDX_W-1:0]     cur_idx;
    logic [WORD_BITS-1:0] cur_word;
    logic [ADDR_W-1:0]    cur_line_base;
    logic [ADDR_W-1:0]    cur_word_addr;

    logic                 rd_valid, rd_dirty, rd_mark;
    logic [TAG_W-1:0]     rd_tag;
    logic [LINE_W-1:0]    rd_line;
    logic                 wr_en, wr_valid, wr_dirty, wr_mark;
    logic [IDX_W-1:0]     wr_idx;
    logic [TAG_W-1:0]     wr_tag;
    logic [LINE_W-1:0]    wr_line;

    ihc_addr_split #(
        .ADDR_W(ADDR_W), .BYTE_OFF(BYTE_OFF), .WORD_BITS(WORD_BITS),
        .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_split (
        .addr      (cur_addr),
        .tag       (cur_tag),
        .idx       (cur_idx),
        .word      (cur_word),
        .line_base (cur_line_base),
        .word_addr (cur_word_addr)
    );

    ihc_line_store #(
        .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_mark  (rd_mark),
        .rd_tag   (rd_tag),
        .rd_line  (rd_line),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_dirty (wr_dirty),
        .wr_mark  (wr_mark),
        .wr_tag   (wr_tag),
        .wr_line  (wr_line)
    );

    ihc_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS),
        .WORD_BITS(WORD_BITS), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .OFF_W(OFF_W), .LINE_W(LINE_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .req_nocache   (req_nocache),
        .priv_mode     (priv_mode),
        .resp_valid    (resp_valid),
        .resp_rdata    (resp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_cmd   (mem_req_cmd),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wline (mem_req_wline),
        .mem_rvalid    (mem_rvalid),
        .mem_rline     (mem_rline),
        .cur_addr      (cur_addr),
        .cur_tag       (cur_tag),
        .cur_idx       (cur_idx),
        .cur_word      (cur_word),
        .cur_line_base (cur_line_base),
        .cur_word_addr (cur_word_addr),
        .rd_valid      (rd_valid),
        .rd_dirty      (rd_dirty),
        .rd_mark       (rd_mark),
        .rd_tag        (rd_tag),
        .rd_line       (rd_line),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_valid      (wr_valid),
        .wr_dirty      (wr_dirty),
        .wr_mark       (wr_mark),
        .wr_tag        (wr_tag),
        .wr_line       (wr_line)
    );

endmodule

// File: rtl/ihc_checker.sv
module ihc_checker #(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic              req_nocache,
    input logic              priv_mode,
    input logic              resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [1:0]        mem_req_cmd,
    input logic [ADDR_W-1:0] mem_req_addr
);
    logic pending_q, inval_q, bypass_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            inval_q   <= 1'b0;
            bypass_q  <= 1'b0;
        end else if (req_valid && req_ready) begin
            pending_q <= 1'b1;
            inval_q   <= (req_op == 2'b10);
            bypass_q  <= req_nocache && priv_mode && (req_op != 2'b10);
        end else if (resp_valid) begin
            pending_q <= 1'b0;
        end
    end

    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !req_ready);

    p_resp_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_resp_owned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> pending_q);

    p_inval_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && inval_q) |-> !mem_req_valid);

    p_inval_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'b10) |-> ##2 resp_valid);

    p_word_cmd_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_cmd[1]) |-> bypass_q);

    p_line_cmd_cached_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_cmd[1]) |-> (pending_q && !bypass_q));

    p_line_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_cmd[1]) |-> (mem_req_addr[OFF_W-1:0] == '0));

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_cmd) && $stable(mem_req_addr)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_q |-> !mem_req_valid);

endmodule

bind inval_hint_dcache ihc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ihc_checker (.*);

// File: tb/tb_inval_hint_dcache.sv
`timescale 1ns/1ps
module tb_inval_hint_dcache;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int LW = 4;
    localparam int MEMW = 1 << (AW - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_nocache = 1'b0;
    logic priv_mode = 1'b0;
    logic resp_valid;
    logic [DW-1:0] resp_rdata;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [1:0] mem_req_cmd;
    logic [AW-1:0] mem_req_addr;
    logic [DW*LW-1:0] mem_req_wline;
    logic mem_rvalid = 1'b0;
    logic [DW*LW-1:0] mem_rline = '0;

    always #5 clk = ~clk;

    inval_hint_dcache dut (.*);

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    int n_lrd = 0, n_lwr = 0, n_wrd = 0, n_wwr = 0;
    int s_lrd, s_lwr, s_wrd, s_wwr;
    int resp_cnt = 0, acc_cyc = 0, resp_cyc = 0;
    int widx;
    logic [DW-1:0] mem  [MEMW];
    logic [DW-1:0] gold [MEMW];

    logic [DW-1:0] q_exp [$];
    bit            q_ld  [$];
    string         q_tag [$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Next-level memory model with a stalling ready.
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        mem_req_ready <= rst_n ? ~mem_req_ready : 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            widx = int'(mem_req_addr[AW-1:2]);
            case (mem_req_cmd)
                2'b00: begin
                    for (int w = 0; w < LW; w++) mem_rline[w*DW +: DW] <= mem[widx + w];
                    mem_rvalid <= 1'b1;
                    n_lrd++;
                end
                2'b01: begin
                    check(mem_req_addr[3:0] == 4'h0, "R11 line write aligned", mem_req_addr, 0);
                    for (int w = 0; w < LW; w++) mem[widx + w] = mem_req_wline[w*DW +: DW];
                    n_lwr++;
                end
                2'b10: begin
                    mem_rline <= {{(DW*(LW-1)){1'b0}}, mem[widx]};
                    mem_rvalid <= 1'b1;
                    n_wrd++;
                end
                default: begin
                    mem[widx] = mem_req_wline[DW-1:0];
                    n_wwr++;
                end
            endcase
        end
    end

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R12 unexpected response", 1, 0);
            end else begin
                logic [DW-1:0] e;
                bit ld;
                string t;
                e = q_exp.pop_front();
                ld = q_ld.pop_front();
                t = q_tag.pop_front();
                if (ld) check(resp_rdata == e, t, resp_rdata, e);
            end
            resp_cyc = cyc;
            resp_cnt++;
        end
    end

    task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input logic nc, input logic pr, input logic [DW-1:0] exp,
                       input bit ld, input string tag);
        int target;
        target = resp_cnt + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        req_nocache = nc; priv_mode = pr;
        q_exp.push_back(exp); q_ld.push_back(ld); q_tag.push_back(tag);
        @(posedge clk);
        #1;
        acc_cyc = cyc;
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b0, "R12 ready low while busy", req_ready, 0);
        while (resp_cnt < target) @(posedge clk);
    endtask

    task automatic ld(input logic [AW-1:0] a, input logic nc, input logic pr, input string tag);
        run(2'b00, a, '0, nc, pr, gold[a[AW-1:2]], 1'b1, tag);
    endtask

    task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        gold[a[AW-1:2]] = d;
        run(2'b01, a, d, 1'b0, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic inv(input logic [AW-1:0] a, input string tag);
        run(2'b10, a, '0, 1'b0, 1'b0, '0, 1'b0, tag);
        check(resp_cyc - acc_cyc == 1, "R7 invalidate latency", resp_cyc - acc_cyc, 1);
    endtask

    task automatic snap();
        s_lrd = n_lrd; s_lwr = n_lwr; s_wrd = n_wrd; s_wwr = n_wwr;
    endtask

    task automatic traffic(input string tag, input int lrd, input int lwr, input int wrd, input int wwr);
        check(n_lrd - s_lrd == lrd, {tag, " line reads"}, n_lrd - s_lrd, lrd);
        check(n_lwr - s_lwr == lwr, {tag, " line writes"}, n_lwr - s_lwr, lwr);
        check(n_wrd - s_wrd == wrd, {tag, " word reads"}, n_wrd - s_wrd, wrd);
        check(n_wwr - s_wwr == wwr, {tag, " word writes"}, n_wwr - s_wwr, wwr);
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < MEMW; i++) begin
            mem[i]  = 32'hC0DE_0000 ^ (i * 32'h0101_0101);
            gold[i] = mem[i];
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1 no response after reset", resp_valid, 0);
        check(mem_req_valid == 1'b0, "R1 no memory request after reset", mem_req_valid, 0);

        // R2: miss then hit in the same line
        snap(); ld(12'h040, 0, 0, "R2 load miss data"); traffic("R2 miss", 1, 0, 0, 0);
        snap(); ld(12'h044, 0, 0, "R2 load hit data");  traffic("R2 hit", 0, 0, 0, 0);

        // R4: store hit is silent and visible
        snap(); st(12'h048, 32'h1111_2222, "R4 store"); traffic("R4 store hit", 0, 0, 0, 0);
        ld(12'h048, 0, 0, "R4 load after store");

        // R3: alias one capacity away evicts dirty victim first
        snap(); ld(12'h148, 0, 0, "R3 alias load data"); traffic("R3 alias", 1, 1, 0, 0);
        check(mem[12'h048 >> 2] == 32'h1111_2222, "R3 victim written back", mem[12'h048 >> 2], 32'h1111_2222);

        // R4: clean victim replaced without write
        snap(); ld(12'h040, 0, 0, "R4 reload data"); traffic("R4 clean evict", 1, 0, 0, 0);

        // R6: clean invalidate drops the line at once
        snap(); inv(12'h040, "R6 inval clean"); traffic("R6 inval clean", 0, 0, 0, 0);
        mem[12'h044 >> 2] = 32'hFEED_0006; gold[12'h044 >> 2] = 32'hFEED_0006;
        snap(); ld(12'h044, 0, 0, "R6 reload sees new memory"); traffic("R6 refill", 1, 0, 0, 0);

        // R7: invalidate miss
        snap(); inv(12'h3C0, "R7 inval miss"); traffic("R7 inval miss", 0, 0, 0, 0);
        snap(); ld(12'h044, 0, 0, "R7 resident line intact"); traffic("R7 untouched", 0, 0, 0, 0);

        // R5: dirty invalidate defers write-back to next hit
        snap(); st(12'h080, 32'hABCD_0005, "R5 store"); traffic("R5 store miss", 1, 0, 0, 0);
        snap(); inv(12'h080, "R5 inval dirty"); traffic("R5 inval dirty", 0, 0, 0, 0);
        check(mem[12'h080 >> 2] != 32'hABCD_0005, "R5 no early write-back", mem[12'h080 >> 2], 0);
        snap(); ld(12'h084, 0, 0, "R5 load on marked line"); traffic("R5 drop write-back", 0, 1, 0, 0);
        check(mem[12'h080 >> 2] == 32'hABCD_0005, "R5 written data", mem[12'h080 >> 2], 32'hABCD_0005);
        snap(); ld(12'h080, 0, 0, "R5 line dropped data"); traffic("R5 line dropped", 1, 0, 0, 0);

        // R10: store to marked line merges then drops
        st(12'h0C0, 32'h0000_A10A, "R10 first store");
        inv(12'h0C0, "R10 inval");
        snap(); st(12'h0C4, 32'h0000_B10B, "R10 store on marked"); traffic("R10 merge write-back", 0, 1, 0, 0);
        check(mem[12'h0C4 >> 2] == 32'h0000_B10B, "R10 merged word", mem[12'h0C4 >> 2], 32'h0000_B10B);
        check(mem[12'h0C0 >> 2] == 32'h0000_A10A, "R10 earlier word", mem[12'h0C0 >> 2], 32'h0000_A10A);
        snap(); ld(12'h0C4, 0, 0, "R10 reload data"); traffic("R10 dropped", 1, 0, 0, 0);

        // R8: privileged bypass leaves cache untouched
        st(12'h100, 32'h5555_8888, "R8 cached store");
        snap(); run(2'b00, 12'h100, '0, 1'b1, 1'b1, mem[12'h100 >> 2], 1'b1, "R8 bypass read sees memory");
        traffic("R8 bypass read", 0, 0, 1, 0);
        gold[12'h200 >> 2] = 32'h7777_0008;
        snap(); run(2'b01, 12'h200, 32'h7777_0008, 1'b1, 1'b1, '0, 1'b0, "R8 bypass write");
        traffic("R8 bypass write", 0, 0, 0, 1);
        check(mem[12'h200 >> 2] == 32'h7777_0008, "R8 bypass write lane", mem[12'h200 >> 2], 32'h7777_0008);
        snap(); ld(12'h100, 0, 0, "R8 cached copy kept"); traffic("R8 cache untouched", 0, 0, 0, 0);
        snap(); ld(12'h200, 1, 1, "R8 bypass read back"); traffic("R8 bypass read back", 0, 0, 1, 0);

        // R9: attribute ignored without privilege
        snap(); ld(12'h1C0, 1, 0, "R9 unprivileged load"); traffic("R9 allocates", 1, 0, 0, 0);
        snap(); ld(12'h1C4, 1, 0, "R9 unprivileged hit"); traffic("R9 hit", 0, 0, 0, 0);

        // R12: reserved op code behaves as a load
        snap(); run(2'b11, 12'h1C8, '0, 1'b0, 1'b0, gold[12'h1C8 >> 2], 1'b1, "R12 reserved op load");
        traffic("R12 reserved op", 0, 0, 0, 0);

        repeat (4) @(negedge clk);
        check(q_exp.size() == 0, "R12 all responses seen", q_exp.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule